// File: doc/BRIEF.md
# Destructive-Readout Magnetic Memory Cycle Controller

This block sequences every access to a word-organized, coincident-select magnetic memory. The memory is built from one bit plane per data bit. Each plane is a grid of cores, and all planes share the same X and Y select lines. Reading a core clears it, so each access has two phases. A clear phase drives one X line and one Y line, forces the addressed word to zero and captures which bits were set. A restore phase then drives the same lines again. In that phase a per-plane inhibit keeps the chosen bits at zero, and every bit that is not inhibited becomes one.

A requester issues a request with an operation code, an address and write data. The block accepts the request only while it is idle. A plain read puts the sensed word back where it came from. A plain write still runs the clear phase, but it discards what was sensed and stores the new word. A read-modify-write returns the old word and then stalls between the two phases. It leaves that stall only when the requester presents the replacement value with a valid strobe.

The sense output and the inhibit input of each plane share one line. That line carries sense only during the clear phase and inhibit only during the restore phase. A behavioural model of the core planes sits inside the top, so the whole access path is visible at the ports.

Top module: `core_cycle_ctrl`

## Requirements
- R1: `gnt_o` is high only while the controller is idle. A request (`req_i` high while `gnt_o` is high) is accepted at that clock edge. Requests seen while a cycle is in progress are ignored until `gnt_o` rises again.
- R2: An address splits into an X index (the low `X_W` bits) and a Y index (the remaining high bits). During the clear and restore phases, `x_sel_o` has exactly the bit of the X index set, and `y_sel_o` has exactly the bit of the Y index set.
- R3: Outside the clear and restore phases, `x_sel_o`, `y_sel_o` and `line_o` are all zero, and this includes the read-modify-write stall.
- R4: A read (op 2'b00) presents the stored word on `rdata_o` from the end of the clear phase. It writes that word back, so a second read of the same address returns the same value.
- R5: A write (op 2'b01) stores `wdata_i`. During its restore phase, `line_o` carries the bitwise complement of the word being stored, which is the inhibit pattern.
- R6: A read-modify-write (op 2'b10) presents the old word on `rdata_o` and waits with the select lines idle for as many cycles as `wb_valid_i` stays low. On the first cycle that `wb_valid_i` is high, it captures `wb_data_i`, and that value is then stored.
- R7: During the clear phase, `line_o` equals the word held at the address before the access. The shared line never carries sense and inhibit in the same cycle.
- R8: `done_o` is a single-cycle pulse in the cycle after the restore phase. For read and write, the clear phase is the first cycle after acceptance, the restore phase the second and `done_o` the third.
- R9: Only the addressed word changes. Words that share its X index or its Y index keep their contents.
- R10: The reserved op 2'b11 behaves exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the core array |
| req_i | input | 1 | Access request |
| op_i | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Data for a plain write |
| gnt_o | output | 1 | Controller idle and able to accept a request |
| wb_valid_i | input | 1 | Replacement value is present (read-modify-write stall) |
| wb_data_i | input | DATA_W | Replacement value |
| rdata_o | output | DATA_W | Word sensed by the last read or read-modify-write |
| done_o | output | 1 | One-cycle end-of-access pulse |
| x_sel_o | output | 2**X_W | X select lines |
| y_sel_o | output | 2**(ADDR_W-X_W) | Y select lines |
| line_o | output | DATA_W | Shared sense/inhibit line of each plane |

## Verification
Some properties are checked on every cycle. These are the select lines being one-hot in the two phases and silent otherwise, the shared line never serving both roles, the restore phase always following the clear phase, the stall held until the strobe, and `done_o` being a single pulse that blocks acceptance. Other behaviour can only be shown by the directed scenarios, because it depends on stored contents. These are the sensed values, the inhibit patterns, the words restored after a destructive read, the effect of read-modify-write, and the survival of neighbouring words on the same X and Y lines.

// File: rtl/core_pkg.sv
package core_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } cyc_state_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_RSVD  = 2'b11
  } mem_op_e;
endpackage

// File: rtl/core_addr_dec.sv
module core_addr_dec #(
  parameter int IDX_W = 3,
  localparam int N = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             en_i,
  output logic [N-1:0]     sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign sel_o[i] = en_i && (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/core_plane.sv
// Behavioural single bit plane: coincident select, destructive sense.
module core_plane #(
  parameter int XN = 8,
  parameter int YN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XN-1:0] x_sel_i,
  input  logic [YN-1:0] y_sel_i,
  input  logic          clear_i,
  input  logic          set_i,
  input  logic          inhibit_i,
  output logic          sense_o
);
  logic [YN-1:0][XN-1:0] cores_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cores_q <= '0;
    end else begin
      for (int y = 0; y < YN; y++) begin
        for (int x = 0; x < XN; x++) begin
          // only a fully selected core switches; half-selected ones hold
          if (x_sel_i[x] && y_sel_i[y]) begin
            if (clear_i) cores_q[y][x] <= 1'b0;
            else if (set_i && !inhibit_i) cores_q[y][x] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    sense_o = 1'b0;
    for (int y = 0; y < YN; y++) begin
      for (int x = 0; x < XN; x++) begin
        sense_o = sense_o | (clear_i & x_sel_i[x] & y_sel_i[y] & cores_q[y][x]);
      end
    end
  end
endmodule

// File: rtl/core_seq.sv
module core_seq
  import core_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wb_valid_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic [DATA_W-1:0] sense_i,
  output logic              gnt_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              wait_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_word_o,
  output logic [DATA_W-1:0] rdata_o
);
  cyc_state_e        state_q, state_d;
  mem_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q, rdata_q;
  logic              accept;

  assign accept = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_READ;
      ST_READ:  state_d = (op_q == OP_RMW) ? ST_WAIT : ST_WRITE;
      ST_WAIT:  if (wb_valid_i) state_d = ST_WRITE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      word_q  <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= mem_op_e'(op_i);
        addr_q <= addr_i;
        word_q <= wdata_i;
      end
      if (state_q == ST_READ && op_q != OP_WRITE) begin
        rdata_q <= sense_i;
        word_q  <= sense_i;  // restore value unless replaced
      end
      if (state_q == ST_WAIT && wb_valid_i) word_q <= wb_data_i;
    end
  end

  assign gnt_o     = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign rd_en_o   = (state_q == ST_READ);
  assign wr_en_o   = (state_q == ST_WRITE);
  assign wait_o    = (state_q == ST_WAIT);
  assign addr_o    = addr_q;
  assign wr_word_o = word_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int X_W    = 3,
  localparam int Y_W   = ADDR_W - X_W,
  localparam int XN    = 1 << X_W,
  localparam int YN    = 1 << Y_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gnt_o,
  input  logic              wb_valid_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [XN-1:0]     x_sel_o,
  output logic [YN-1:0]     y_sel_o,
  output logic [DATA_W-1:0] line_o
);
  logic              rd_en, wr_en, wait_st, drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wr_word, sense, inhibit;
  logic [XN-1:0]     x_sel;
  logic [YN-1:0]     y_sel;

  core_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wb_valid_i (wb_valid_i),
    .wb_data_i  (wb_data_i),
    .sense_i    (sense),
    .gnt_o      (gnt_o),
    .done_o     (done_o),
    .rd_en_o    (rd_en),
    .wr_en_o    (wr_en),
    .wait_o     (wait_st),
    .addr_o     (addr_q),
    .wr_word_o  (wr_word),
    .rdata_o    (rdata_o)
  );

  assign drive = rd_en | wr_en;

  core_addr_dec #(.IDX_W(X_W)) u_xdec (
    .idx_i (addr_q[X_W-1:0]),
    .en_i  (drive),
    .sel_o (x_sel)
  );

  core_addr_dec #(.IDX_W(Y_W)) u_ydec (
    .idx_i (addr_q[ADDR_W-1:X_W]),
    .en_i  (drive),
    .sel_o (y_sel)
  );

  assign inhibit = ~wr_word;

  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    core_plane #(.XN(XN), .YN(YN)) u_plane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .x_sel_i   (x_sel),
      .y_sel_i   (y_sel),
      .clear_i   (rd_en),
      .set_i     (wr_en),
      .inhibit_i (inhibit[b]),
      .sense_o   (sense[b])
    );
    // shared wire: sense in clear phase, inhibit in restore phase
    assign line_o[b] = rd_en ? sense[b] : (wr_en ? inhibit[b] : 1'b0);
  end

  assign x_sel_o = x_sel;
  assign y_sel_o = y_sel;
endmodule

// File: rtl/core_cycle_chk.sv
module core_cycle_chk #(
  parameter int XN     = 8,
  parameter int YN     = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gnt_i,
  input logic              done_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic              wait_i,
  input logic              wb_valid_i,
  input logic [XN-1:0]     x_sel_i,
  input logic [YN-1:0]     y_sel_i,
  input logic [DATA_W-1:0] line_i,
  input logic [DATA_W-1:0] rdata_i
);
  p_busy_no_grant_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i || wait_i || done_i) |-> !gnt_i);

  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i || wr_en_i) |-> ($countones(x_sel_i) == 1 && $countones(y_sel_i) == 1));

  p_sel_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i || wr_en_i) |-> (x_sel_i == '0 && y_sel_i == '0 && line_i == '0));

  p_restore_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (wr_en_i || wait_i));

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !wb_valid_i) |=> (wait_i && $stable(rdata_i)));

  p_stall_leave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && wb_valid_i) |=> wr_en_i);

  p_line_roles_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i));

  p_done_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> done_i);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && gnt_i));
endmodule

bind core_cycle_ctrl core_cycle_chk #(.XN(XN), .YN(YN), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gnt_i      (gnt_o),
  .done_i     (done_o),
  .rd_en_i    (rd_en),
  .wr_en_i    (wr_en),
  .wait_i     (wait_st),
  .wb_valid_i (wb_valid_i),
  .x_sel_i    (x_sel_o),
  .y_sel_i    (y_sel_o),
  .line_i     (line_o),
  .rdata_i    (rdata_o)
);

// File: tb/sim_core_cycle_ctrl.sv
module sim_core_cycle_ctrl;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int X_W    = 3;
  localparam int XN     = 1 << X_W;
  localparam int YN     = 1 << (ADDR_W - X_W);
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [1:0]        op = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              gnt, done;
  logic              wb_valid = 1'b0;
  logic [DATA_W-1:0] wb_data = '0;
  logic [DATA_W-1:0] rdata, line;
  logic [XN-1:0]     x_sel;
  logic [YN-1:0]     y_sel;

  int n_chk = 0;
  int n_fail = 0;
  logic [DATA_W-1:0] model [WORDS];

  always #10 clk = ~clk;  // 50 MHz

  core_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .X_W(X_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .wb_valid_i(wb_valid), .wb_data_i(wb_data),
    .rdata_o(rdata), .done_o(done), .x_sel_o(x_sel), .y_sel_o(y_sel), .line_o(line)
  );

  task automatic check(input logic ok, input string req_tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [XN-1:0] x_of(input logic [ADDR_W-1:0] a);
    return XN'(1) << a[X_W-1:0];
  endfunction

  function automatic logic [YN-1:0] y_of(input logic [ADDR_W-1:0] a);
    return YN'(1) << a[ADDR_W-1:X_W];
  endfunction

  // One access; stall_cyc is the number of idle strobe cycles in an RMW stall.
  task automatic access(input logic [1:0] o, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] wbv,
                        input int stall_cyc, output logic [DATA_W-1:0] got);
    logic [DATA_W-1:0] old, nw;
    old = model[a];
    nw  = (o == 2'b01) ? wd : ((o == 2'b10) ? wbv : old);
    @(negedge clk);
    check(gnt == 1'b1, "R1", gnt, 1);
    req = 1'b1; op = o; addr = a; wdata = wd;
    @(negedge clk);  // clear phase
    // keep req high with other values: must be ignored while busy
    op = 2'b01; addr = ~a; wdata = 8'h5a;
    check(gnt == 1'b0, "R1", gnt, 0);
    check(x_sel == x_of(a) && y_sel == y_of(a), "R2", {x_sel, y_sel}, {x_of(a), y_of(a)});
    check(line == old, "R7", line, old);
    if (o == 2'b10) begin
      for (int i = 0; i < stall_cyc + 1; i++) begin
        @(negedge clk);
        check(x_sel == '0 && y_sel == '0 && line == '0, "R3", {x_sel, y_sel, line}, 0);
        check(rdata == old, "R6", rdata, old);
      end
      wb_valid = 1'b1; wb_data = wbv;
      @(negedge clk);
      wb_valid = 1'b0; wb_data = 8'hff;
    end else begin
      @(negedge clk);
    end
    // restore phase
    check(x_sel == x_of(a) && y_sel == y_of(a), "R2", {x_sel, y_sel}, {x_of(a), y_of(a)});
    check(line == ~nw, "R5", line, ~nw);
    if (o != 2'b01) check(rdata == old, "R4", rdata, old);
    req = 1'b0;
    @(negedge clk);
    check(done == 1'b1 && gnt == 1'b0, "R8", {done, gnt}, 2'b10);
    check(x_sel == '0 && line == '0, "R3", {x_sel, line}, 0);
    @(negedge clk);
    check(done == 1'b0 && gnt == 1'b1, "R8", {done, gnt}, 2'b01);
    model[a] = nw;
    got = rdata;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] g;
    check(gnt == 1'b1 && done == 1'b0 && x_sel == '0 && y_sel == '0, "R3",
          {gnt, done, x_sel, y_sel}, {2'b10, 16'h0});
    access(2'b00, 6'd9, '0, '0, 0, g);
    check(g == '0, "R4", g, 0);
  endtask

  task automatic t_write_read();
    logic [DATA_W-1:0] g;
    access(2'b01, 6'd21, 8'ha5, '0, 0, g);
    access(2'b00, 6'd21, '0, '0, 0, g);
    check(g == 8'ha5, "R4", g, 8'ha5);
    access(2'b00, 6'd21, '0, '0, 0, g);  // destructive read was restored
    check(g == 8'ha5, "R4", g, 8'ha5);
    access(2'b01, 6'd21, 8'h3c, '0, 0, g);  // overwrite clears old 1s
    access(2'b00, 6'd21, '0, '0, 0, g);
    check(g == 8'h3c, "R5", g, 8'h3c);
    access(2'b01, 6'd63, 8'hff, '0, 0, g);
    access(2'b01, 6'd0, 8'h81, '0, 0, g);
    access(2'b00, 6'd63, '0, '0, 0, g);
    check(g == 8'hff, "R5", g, 8'hff);
  endtask

  task automatic t_rmw();
    logic [DATA_W-1:0] g;
    access(2'b01, 6'd42, 8'h0f, '0, 0, g);
    access(2'b10, 6'd42, '0, 8'h10, 3, g);
    check(g == 8'h0f, "R6", g, 8'h0f);
    access(2'b10, 6'd42, '0, 8'h11, 0, g);
    check(g == 8'h10, "R6", g, 8'h10);
    access(2'b00, 6'd42, '0, '0, 0, g);
    check(g == 8'h11, "R6", g, 8'h11);
  endtask

  task automatic t_neighbours();
    logic [DATA_W-1:0] g;
    // 27: x=3,y=3; 19: x=3,y=2 (same X); 29: x=5,y=3 (same Y)
    access(2'b01, 6'd19, 8'hc3, '0, 0, g);
    access(2'b01, 6'd29, 8'h66, '0, 0, g);
    access(2'b01, 6'd27, 8'h00, '0, 0, g);
    access(2'b01, 6'd27, 8'hff, '0, 0, g);
    access(2'b00, 6'd19, '0, '0, 0, g);
    check(g == 8'hc3, "R9", g, 8'hc3);
    access(2'b00, 6'd29, '0, '0, 0, g);
    check(g == 8'h66, "R9", g, 8'h66);
    access(2'b00, 6'd27, '0, '0, 0, g);
    check(g == 8'hff, "R9", g, 8'hff);
  endtask

  task automatic t_reserved_op();
    logic [DATA_W-1:0] g;
    access(2'b01, 6'd50, 8'h9e, '0, 0, g);
    access(2'b11, 6'd50, 8'h00, '0, 0, g);
    check(g == 8'h9e, "R10", g, 8'h9e);
    access(2'b00, 6'd50, '0, '0, 0, g);
    check(g == 8'h9e, "R10", g, 8'h9e);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_rmw();
    t_neighbours();
    t_reserved_op();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule